// File: doc/BRIEF.md
# Segmented Carry-Pipelined Wide Accumulator

This block sums a stream of wide unsigned operands into a running total much wider than any single adder in it. The total is cut into narrow segments of `SLICE_W` bits. Each segment is owned by its own accumulation stage. A stage hands its carry to the next more significant stage through a register, so no carry ever ripples further than one segment within a clock cycle. The operand's slices are skewed on the way in so that stage `j` handles slice `j` exactly when the carry from the same operand reaches it from stage `j-1`. The segments of the result are then brought back into line on the way out, so the whole total appears at once.

One operand can be accepted on every cycle. An operand flagged as a clear discards the old total and becomes the new one. An operand flagged as last makes the total, including that operand, appear on the output a fixed number of cycles later. That delay equals the stage count. The stage count is `ceil((IN_W + clog2(MAX_TERMS)) / SLICE_W)`, so up to `MAX_TERMS` operands since the last clear can never overflow the total. With the defaults (`SLICE_W`=8, `IN_SLICES`=4, `MAX_TERMS`=16) the input is 32 bits wide, there are 5 stages, and the total is 40 bits wide.

Top module: `seg_carry_acc`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `sum_valid` is 0 and `sum_data` is all zeros. The running total starts from zero after reset.
- R2: The total reported is exactly the unsigned sum of every accepted operand since the last clear (or since reset), as a full-width adder would give.
- R3: `sum_valid` is high for one cycle, exactly STAGES clock edges after the edge that accepted an operand with `in_valid`=1 and `in_last`=1. It is high at no other time.
- R4: An accepted operand with `in_clr`=1 replaces the running total with its own value. Later operands add to it.
- R5: Cycles with `in_valid`=0 add nothing to the total, and they do not lose a carry that is still moving between stages.
- R6: A reported total does not end the accumulation. Operands flagged last on consecutive cycles each report the running total up to and including themselves.
- R7: Back-to-back all-ones operands, whose carries move through every stage, give the exact total. Sixteen such 32-bit operands give 0xF_FFFF_FFF0.
- R8: Between `sum_valid` pulses, `sum_data` holds the last reported total unchanged.
- R9: The most significant stage never produces a carry out when at most MAX_TERMS operands have been accepted since the last clear.
- R10: `in_clr` and `in_last` have no effect on a cycle where `in_valid` is 0. No result is reported, and the total is not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present on this cycle |
| in_clr | input | 1 | With `in_valid`, this operand starts a new total |
| in_last | input | 1 | With `in_valid`, report the total after this operand |
| in_data | input | SLICE_W*IN_SLICES | Unsigned operand |
| sum_valid | output | 1 | One-cycle pulse marking a new total on `sum_data` |
| sum_data | output | STAGES*SLICE_W | Registered total; held between pulses |

## Verification
The bound checker runs its own full-width running total on every cycle. From that model it checks four things:
- each `sum_valid` pulse comes exactly the stage count after an accepted last-flagged operand;
- every reported total equals the model's value;
- `sum_data` stays still between pulses;
- the top stage never carries out.

Other behaviours only show up through the bench's scenarios, because they depend on which operands are chosen:
- carries moving through every stage under back-to-back all-ones operands;
- bubbles placed between carry-producing operands;
- a clear arriving in the middle of a stream;
- flags that are ignored while `in_valid` is low.

// File: rtl/seg_acc_pkg.sv
package seg_acc_pkg;
  // Number of SLICE_W-bit segments needed so that max_terms operands of
  // slice_w*in_slices bits can be summed without losing the top carry.
  function automatic int unsigned stage_count(int unsigned slice_w,
                                              int unsigned in_slices,
                                              int unsigned max_terms);
    return (slice_w * in_slices + $clog2(max_terms) + slice_w - 1) / slice_w;
  endfunction
endpackage

// File: rtl/seg_delay.sv
module seg_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] sr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else begin
      sr[0] <= d;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  assign q = sr[DEPTH-1];
endmodule

// File: rtl/seg_stage.sv
module seg_stage #(
  parameter int SLICE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic               restart,
  input  logic [SLICE_W-1:0] slice,
  input  logic               cin,
  output logic [SLICE_W-1:0] part,
  output logic               cout
);
  logic [SLICE_W-1:0] base;
  logic [SLICE_W-1:0] addend;
  logic [SLICE_W:0]   nxt;

  always_comb begin
    base   = (take && restart) ? '0 : part;
    addend = take ? slice : '0;
    nxt    = {1'b0, base} + {1'b0, addend} + {{SLICE_W{1'b0}}, cin};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      part <= '0;
      cout <= 1'b0;
    end else begin
      part <= nxt[SLICE_W-1:0];
      cout <= nxt[SLICE_W];
    end
  end
endmodule

// File: rtl/seg_carry_acc.sv
module seg_carry_acc #(
  parameter int SLICE_W   = 8,
  parameter int IN_SLICES = 4,
  parameter int MAX_TERMS = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid,
  input  logic                                 in_clr,
  input  logic                                 in_last,
  input  logic [SLICE_W*IN_SLICES-1:0]         in_data,
  output logic                                 sum_valid,
  output logic [seg_acc_pkg::stage_count(SLICE_W, IN_SLICES, MAX_TERMS)*SLICE_W-1:0] sum_data
);
  localparam int IN_W   = SLICE_W * IN_SLICES;
  localparam int STAGES = seg_acc_pkg::stage_count(SLICE_W, IN_SLICES, MAX_TERMS);
  localparam int ACC_W  = STAGES * SLICE_W;

  logic [STAGES:0]    carry;
  logic [STAGES-1:0]  stg_vld;
  logic [STAGES-1:0]  stg_clr;
  logic [SLICE_W-1:0] stg_slice [STAGES];
  logic [SLICE_W-1:0] stg_part  [STAGES];
  logic [ACC_W-1:0]   aligned_flat;
  logic               last_al;
  logic               top_carry;

  assign carry[0]  = 1'b0;
  assign top_carry = carry[STAGES];

  for (genvar j = 0; j < STAGES; j++) begin : g_stage
    // Control skew: stage j sees the operand's flags j cycles late.
    if (j == 0) begin : g_ctl0
      assign stg_vld[j] = in_valid;
      assign stg_clr[j] = in_clr;
    end else begin : g_ctld
      logic [1:0] ctl_q;
      seg_delay #(.W(2), .DEPTH(j)) ctl_dly_i (
        .clk(clk), .rst(rst), .d({in_valid, in_clr}), .q(ctl_q)
      );
      assign stg_vld[j] = ctl_q[1];
      assign stg_clr[j] = ctl_q[0];
    end

    // Data skew: only stages covering an input slice get data.
    if (j >= IN_SLICES) begin : g_pad
      assign stg_slice[j] = '0;
    end else if (j == 0) begin : g_dat0
      assign stg_slice[j] = in_data[SLICE_W-1:0];
    end else begin : g_datd
      seg_delay #(.W(SLICE_W), .DEPTH(j)) dat_dly_i (
        .clk(clk), .rst(rst), .d(in_data[j*SLICE_W +: SLICE_W]), .q(stg_slice[j])
      );
    end

    seg_stage #(.SLICE_W(SLICE_W)) stage_i (
      .clk(clk), .rst(rst),
      .take(stg_vld[j]), .restart(stg_clr[j]),
      .slice(stg_slice[j]), .cin(carry[j]),
      .part(stg_part[j]), .cout(carry[j+1])
    );

    // Output deskew: lower segments wait for the top one.
    if (j == STAGES - 1) begin : g_out0
      assign aligned_flat[j*SLICE_W +: SLICE_W] = stg_part[j];
    end else begin : g_outd
      seg_delay #(.W(SLICE_W), .DEPTH(STAGES - 1 - j)) out_dly_i (
        .clk(clk), .rst(rst), .d(stg_part[j]),
        .q(aligned_flat[j*SLICE_W +: SLICE_W])
      );
    end
  end

  seg_delay #(.W(1), .DEPTH(STAGES)) last_dly_i (
    .clk(clk), .rst(rst), .d(in_valid & in_last), .q(last_al)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_valid <= 1'b0;
      sum_data  <= '0;
    end else begin
      sum_valid <= last_al;
      if (last_al) sum_data <= aligned_flat;
    end
  end
endmodule

// File: rtl/seg_carry_acc_chk.sv
module seg_carry_acc_chk #(
  parameter int SLICE_W   = 8,
  parameter int IN_SLICES = 4,
  parameter int MAX_TERMS = 16
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic                                 in_valid,
  input logic                                 in_clr,
  input logic                                 in_last,
  input logic [SLICE_W*IN_SLICES-1:0]         in_data,
  input logic                                 sum_valid,
  input logic [seg_acc_pkg::stage_count(SLICE_W, IN_SLICES, MAX_TERMS)*SLICE_W-1:0] sum_data,
  input logic                                 top_carry
);
  localparam int STAGES = seg_acc_pkg::stage_count(SLICE_W, IN_SLICES, MAX_TERMS);
  localparam int ACC_W  = STAGES * SLICE_W;

  logic [ACC_W-1:0] tot;
  logic [ACC_W-1:0] tot_nxt;
  logic             vsr [STAGES+1];
  logic [ACC_W-1:0] esr [STAGES+1];

  always_comb begin
    tot_nxt = tot;
    if (in_valid) tot_nxt = in_clr ? ACC_W'(in_data) : tot + ACC_W'(in_data);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tot <= '0;
      for (int i = 0; i <= STAGES; i++) begin
        vsr[i] <= 1'b0;
        esr[i] <= '0;
      end
    end else begin
      tot    <= tot_nxt;
      vsr[0] <= in_valid & in_last;
      esr[0] <= tot_nxt;
      for (int i = 1; i <= STAGES; i++) begin
        vsr[i] <= vsr[i-1];
        esr[i] <= esr[i-1];
      end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!sum_valid && sum_data == '0));

  // R3
  result_latency_chk: assert property (@(posedge clk) disable iff (rst)
    sum_valid == vsr[STAGES]);

  // R2
  exact_total_chk: assert property (@(posedge clk) disable iff (rst)
    sum_valid |-> sum_data == esr[STAGES]);

  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !sum_valid |-> $stable(sum_data));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !top_carry);
endmodule

bind seg_carry_acc seg_carry_acc_chk #(
  .SLICE_W(SLICE_W), .IN_SLICES(IN_SLICES), .MAX_TERMS(MAX_TERMS)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_clr(in_clr),
  .in_last(in_last), .in_data(in_data), .sum_valid(sum_valid),
  .sum_data(sum_data), .top_carry(top_carry)
);

// File: tb/seg_carry_acc_tb_top.sv
`timescale 1ns/1ps
module seg_carry_acc_tb_top;
  localparam int P     = 8;
  localparam int NS    = 4;
  localparam int NT    = 16;
  localparam int IN_W  = P * NS;
  localparam int LAT   = (IN_W + $clog2(NT) + P - 1) / P;
  localparam int ACC_W = LAT * P;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic v = 1'b0, c = 1'b0, l = 1'b0;
  logic [IN_W-1:0]  d = '0;
  logic             sv;
  logic [ACC_W-1:0] sd;

  always #2.5 clk = ~clk;

  seg_carry_acc #(.SLICE_W(P), .IN_SLICES(NS), .MAX_TERMS(NT)) dut_i (
    .clk(clk), .rst(rst), .in_valid(v), .in_clr(c), .in_last(l),
    .in_data(d), .sum_valid(sv), .sum_data(sd)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";
  int due_q[$];
  logic [ACC_W-1:0] val_q[$];
  logic [ACC_W-1:0] held = '0;
  logic [ACC_W-1:0] run  = '0;

  task automatic chk(string req, logic [ACC_W-1:0] act, logic [ACC_W-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    logic exp_v;
    exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
    if (exp_v) begin
      held = val_q[0];
      void'(due_q.pop_front());
      void'(val_q.pop_front());
    end
    chk("R3", ACC_W'(sv), ACC_W'(exp_v), "sum_valid");
    chk(tag, sd, held, "sum_data");
  endtask

  task automatic step(bit vi, bit ci, bit li, logic [IN_W-1:0] di);
    @(negedge clk);
    compare();
    v = vi; c = ci; l = li; d = di;
    if (vi) begin
      run = ci ? ACC_W'(di) : run + ACC_W'(di);
      if (li) begin
        due_q.push_back(cyc + 1 + LAT);
        val_q.push_back(run);
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs after reset
    chk("R1", ACC_W'(sv), '0, "sum_valid in reset");
    chk("R1", sd, '0, "sum_data in reset");
    rst = 1'b0;
    idle(2);

    // R2: plain group
    tag = "R2";
    step(1, 1, 0, 32'h1234_5678);
    step(1, 0, 0, 32'h9ABC_DEF0);
    step(1, 0, 1, 32'h0F0F_F0F0);
    tag = "R8"; idle(LAT + 3);

    // R5: bubbles between carry-producing terms
    tag = "R5";
    step(1, 1, 0, 32'hFFFF_FFFF);
    step(0, 0, 0, '0);
    step(1, 0, 0, 32'h0000_0001);
    step(0, 0, 0, '0);
    step(0, 0, 0, '0);
    step(1, 0, 1, 32'h8000_0000);
    tag = "R8"; idle(LAT + 2);

    // R6: consecutive last flags, running totals
    tag = "R6";
    step(1, 1, 1, 32'd5);
    step(1, 0, 1, 32'd7);
    step(1, 1, 1, 32'd3);
    step(1, 0, 1, 32'd1);
    step(1, 0, 1, 32'hFFFF_FF00);
    tag = "R8"; idle(LAT + 2);

    // R4: clear in the middle of a stream
    tag = "R4";
    step(1, 1, 0, 32'hFFFF_0000);
    step(1, 0, 0, 32'hFFFF_0000);
    step(1, 1, 0, 32'd50);
    step(1, 0, 1, 32'd25);
    tag = "R8"; idle(LAT + 2);

    // R7/R9: back-to-back all-ones, max terms, two groups
    tag = "R7/R9";
    for (int g = 0; g < 2; g++)
      for (int i = 0; i < NT; i++)
        step(1, i == 0, i == NT - 1, '1);
    tag = "R8"; idle(LAT + 2);
    chk("R7", held, 40'hF_FFFF_FFF0, "model all-ones total");

    // R10: flags ignored without in_valid
    tag = "R10";
    step(1, 1, 0, 32'd10);
    step(0, 1, 1, 32'hFFFF_FFFF);
    idle(LAT + 2);
    step(1, 0, 1, 32'd20);
    tag = "R8"; idle(LAT + 3);
    chk("R10", sd, 40'd30, "total after ignored flags");

    summary();
    $finish;
  end
endmodule